// File: doc/BRIEF.md
# Replicated Two-Cluster Register File

This block holds the architectural integer registers of a four-wide in-order core whose execution units are split into two clusters. There is no single shared array. Each cluster keeps its own full copy of the 32 registers, 64 bits each. Each copy carries read ports only for the two instructions that run in its cluster, which gives four operand ports per copy instead of eight on a shared array.

All four write slots are sent to both copies on the same clock edge, so the copies never drift apart. Two write slots may name the same register in one cycle. The arbitration inside the block then lets only the youngest slot write. Register 0 is hard-wired to zero.

Reads are registered. An address presented in one cycle yields data on the next rising edge. That data is the value held before any write on that same edge. Forwarding of results written in the same cycle is left to the bypass network outside the block.

Top module: `clustered_regfile`

## Requirements
- R1: Read port p (0 to 7) belongs to cluster p/4. Ports 0-3 are served by copy 0 and ports 4-7 by copy 1. Each port returns the value of the register named by its address.
- R2: Every write is applied to both copies on the same edge. Two ports in different clusters that read the same register on the same cycle return the same value.
- R3: Read data appears on `rd_data` at the first rising edge after the address is presented. It is held until the next edge.
- R4: A read of a register that is written on the same edge returns the value from before that write. The new value is returned from the following edge on.
- R5: If several enabled write slots name the same register in one cycle, the slot with the highest index (the youngest) takes effect. Older slots to that register are dropped.
- R6: Register 0 always reads as zero. A write to register 0 has no effect.
- R7: While `rst` is high on a rising edge, all entries of both copies and all read outputs are cleared to zero.
- R8: A write slot whose enable bit is low changes no register, whatever its address and data.
- R9: Slot i of a flat bus occupies bits [i*W +: W]. W is 5 for addresses and 64 for data. Bit i of `wr_en` enables write slot i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 4 | Per-slot write enable; a higher index is younger |
| wr_addr | input | 20 | Four 5-bit write register numbers |
| wr_data | input | 256 | Four 64-bit write values |
| rd_addr | input | 40 | Eight 5-bit read register numbers; ports 0-3 for cluster 0, ports 4-7 for cluster 1 |
| rd_data | output | 512 | Eight 64-bit registered read values |

## Verification
Every read result is due exactly one rising edge after its address is driven. The bench drives inputs on the falling edge. It compares each port on the following falling edge, half a period after the edge that loaded the output. The reference model uses its contents from before the writes of that cycle, which covers the read-before-write ordering. Write effects are first visible to an address driven after the writing edge, so they are checked two falling edges after the write is driven. Directed sequences force slot collisions, writes to register 0, disabled slots and reset during traffic. A final sweep reads every register through both clusters on the same cycle to show the two copies agree.

// File: rtl/crf_pkg.sv
package crf_pkg;

  localparam int DEF_NUM_REGS     = 32;
  localparam int DEF_DATA_W       = 64;
  localparam int DEF_ISSUE_W      = 4;
  localparam int DEF_NUM_CLUSTERS = 2;
  localparam int DEF_SRCS         = 2;

  // operand ports each copy needs: sources per insn times insns per cluster
  function automatic int ports_per_copy(int issue_w, int clusters, int srcs);
    return (srcs * issue_w) / clusters;
  endfunction

endpackage

// File: rtl/crf_wr_arbiter.sv
module crf_wr_arbiter #(
  parameter int NW = 4,
  parameter int AW = 5
) (
  input  logic [NW-1:0]    wr_en,
  input  logic [NW*AW-1:0] wr_addr,
  output logic [NW-1:0]    eff_en
);

  // a slot survives if enabled, not register 0, and no younger slot hits it
  always_comb begin
    for (int i = 0; i < NW; i++) begin
      eff_en[i] = wr_en[i] && (wr_addr[i*AW +: AW] != '0);
      for (int j = i + 1; j < NW; j++) begin
        if (wr_en[j] && (wr_addr[j*AW +: AW] == wr_addr[i*AW +: AW]))
          eff_en[i] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/crf_replica.sv
module crf_replica #(
  parameter int NUM_REGS = 32,
  parameter int DW       = 64,
  parameter int NW       = 4,
  parameter int NR       = 4,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NW-1:0]    wr_en,
  input  logic [NW*AW-1:0] wr_addr,
  input  logic [NW*DW-1:0] wr_data,
  input  logic [NR*AW-1:0] rd_addr,
  output logic [NR*DW-1:0] rd_data
);

  logic [DW-1:0] mem [NUM_REGS];
  logic [NR*DW-1:0] rd_q;

  // write side: enables arrive already exclusive per register
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) mem[r] <= '0;
    end else begin
      for (int i = 0; i < NW; i++) begin
        if (wr_en[i]) mem[wr_addr[i*AW +: AW]] <= wr_data[i*DW +: DW];
      end
    end
  end

  // read side: registered, returns pre-write contents
  generate
    for (genvar p = 0; p < NR; p++) begin : g_rd
      always_ff @(posedge clk) begin
        if (rst) begin
          rd_q[p*DW +: DW] <= '0;
        end else if (rd_addr[p*AW +: AW] == '0) begin
          rd_q[p*DW +: DW] <= '0;
        end else begin
          rd_q[p*DW +: DW] <= mem[rd_addr[p*AW +: AW]];
        end
      end
    end
  endgenerate

  assign rd_data = rd_q;

endmodule

// File: rtl/clustered_regfile.sv
module clustered_regfile
  import crf_pkg::*;
#(
  parameter int NUM_REGS     = DEF_NUM_REGS,
  parameter int DATA_W       = DEF_DATA_W,
  parameter int ISSUE_W      = DEF_ISSUE_W,
  parameter int NUM_CLUSTERS = DEF_NUM_CLUSTERS,
  parameter int SRCS         = DEF_SRCS,
  localparam int AW          = $clog2(NUM_REGS),
  localparam int RD_PER_CL   = ports_per_copy(ISSUE_W, NUM_CLUSTERS, SRCS),
  localparam int RD_TOTAL    = RD_PER_CL * NUM_CLUSTERS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ISSUE_W-1:0]         wr_en,
  input  logic [ISSUE_W*AW-1:0]      wr_addr,
  input  logic [ISSUE_W*DATA_W-1:0]  wr_data,
  input  logic [RD_TOTAL*AW-1:0]     rd_addr,
  output logic [RD_TOTAL*DATA_W-1:0] rd_data
);

  logic [ISSUE_W-1:0] wr_eff;

  crf_wr_arbiter #(
    .NW (ISSUE_W),
    .AW (AW)
  ) u_arb (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .eff_en  (wr_eff)
  );

  generate
    for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_copy
      crf_replica #(
        .NUM_REGS (NUM_REGS),
        .DW       (DATA_W),
        .NW       (ISSUE_W),
        .NR       (RD_PER_CL)
      ) u_rep (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_eff),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr[c*RD_PER_CL*AW +: RD_PER_CL*AW]),
        .rd_data (rd_data[c*RD_PER_CL*DATA_W +: RD_PER_CL*DATA_W])
      );
    end
  endgenerate

endmodule

// File: rtl/crf_checker.sv
module crf_checker #(
  parameter int AW        = 5,
  parameter int DW        = 64,
  parameter int NW        = 4,
  parameter int RD_PER_CL = 4,
  parameter int RD_TOTAL  = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NW-1:0]        wr_en,
  input logic [NW*AW-1:0]     wr_addr,
  input logic [NW-1:0]        eff_en,
  input logic [RD_TOTAL*AW-1:0] rd_addr,
  input logic [RD_TOTAL*DW-1:0] rd_data
);

  // R7: an edge with reset high leaves every output at zero
  p_reset_clear_r7: assert property (@(posedge clk)
    $past(rst) |-> rd_data == '0);

  generate
    for (genvar p = 0; p < RD_TOTAL; p++) begin : g_port
      // R6: register 0 reads as zero one edge later
      p_zero_reg_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rd_addr[p*AW +: AW]) == '0 |-> rd_data[p*DW +: DW] == '0);
    end

    for (genvar q = 0; q < RD_PER_CL; q++) begin : g_pair
      // R2: both copies agree when the same register is read
      p_copies_agree_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rd_addr[q*AW +: AW]) == $past(rd_addr[(RD_PER_CL+q)*AW +: AW])
        |-> rd_data[q*DW +: DW] == rd_data[(RD_PER_CL+q)*DW +: DW]);
    end

    for (genvar i = 0; i < NW; i++) begin : g_slot
      // R6: register 0 never receives a write
      p_no_zero_write_r6: assert property (@(posedge clk) disable iff (rst)
        eff_en[i] |-> wr_addr[i*AW +: AW] != '0);
      // R8: a disabled slot never writes
      p_disabled_slot_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en[i] |-> !eff_en[i]);
      for (genvar j = i + 1; j < NW; j++) begin : g_younger
        // R5: the older of two colliding slots is dropped
        p_younger_wins_r5: assert property (@(posedge clk) disable iff (rst)
          (wr_en[j] && wr_en[i] && wr_addr[i*AW +: AW] == wr_addr[j*AW +: AW])
          |-> !eff_en[i]);
      end
    end
  endgenerate

endmodule

bind clustered_regfile crf_checker #(
  .AW        (AW),
  .DW        (DATA_W),
  .NW        (ISSUE_W),
  .RD_PER_CL (RD_PER_CL),
  .RD_TOTAL  (RD_TOTAL)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .eff_en  (wr_eff),
  .rd_addr (rd_addr),
  .rd_data (rd_data)
);

// File: tb/clustered_regfile_tb_top.sv
module clustered_regfile_tb_top;

  localparam int NREG = 32;
  localparam int AW   = 5;
  localparam int DW   = 64;
  localparam int NW   = 4;
  localparam int NR   = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NW-1:0]    wr_en = '0;
  logic [NW*AW-1:0] wr_addr = '0;
  logic [NW*DW-1:0] wr_data = '0;
  logic [NR*AW-1:0] rd_addr = '0;
  logic [NR*DW-1:0] rd_data;

  always #10 clk = ~clk;  // 50 MHz

  clustered_regfile dut_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [DW-1:0] refm [NREG];
  logic [DW-1:0] expv [NR];
  bit            exp_ok = 0;
  string         exp_tag = "";

  logic [3:0]    s_en;
  logic [AW-1:0] s_wa [NW];
  logic [DW-1:0] s_wd [NW];
  logic [AW-1:0] s_ra [NR];

  task automatic clear_stim();
    s_en = '0;
    for (int i = 0; i < NW; i++) begin s_wa[i] = '0; s_wd[i] = '0; end
    for (int p = 0; p < NR; p++) s_ra[p] = '0;
  endtask

  // one falling edge: check last results, then drive the staged stimulus
  task automatic step(string tag);
    @(negedge clk);
    if (exp_ok) begin
      for (int p = 0; p < NR; p++) begin
        checks++;
        if (rd_data[p*DW +: DW] !== expv[p]) begin
          errors++;
          $display("FAIL %s port %0d: actual %h expected %h", exp_tag, p,
                   rd_data[p*DW +: DW], expv[p]);
        end
      end
    end
    for (int p = 0; p < NR; p++) expv[p] = refm[s_ra[p]];
    for (int i = 0; i < NW; i++)
      if (s_en[i] && s_wa[i] != '0) refm[s_wa[i]] = s_wd[i];
    for (int i = 0; i < NW; i++) begin
      wr_addr[i*AW +: AW] = s_wa[i];
      wr_data[i*DW +: DW] = s_wd[i];
    end
    for (int p = 0; p < NR; p++) rd_addr[p*AW +: AW] = s_ra[p];
    wr_en   = s_en;
    exp_ok  = 1;
    exp_tag = tag;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wr_en = '0;
    exp_ok = 0;
    for (int r = 0; r < NREG; r++) refm[r] = '0;
    repeat (2) @(negedge clk);
    for (int p = 0; p < NR; p++) begin
      checks++;
      if (rd_data[p*DW +: DW] !== '0) begin
        errors++;
        $display("FAIL R7 port %0d under reset: actual %h expected 0", p,
                 rd_data[p*DW +: DW]);
      end
    end
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    clear_stim();
    do_reset();

    // R9 / R1: distinct values on distinct registers, distinct port addresses
    for (int i = 0; i < NW; i++) begin
      s_en[i] = 1'b1; s_wa[i] = AW'(i + 1); s_wd[i] = {32'hA000_0000 + i, 32'h1234_0000 + i};
    end
    step("R9");
    clear_stim();
    for (int p = 0; p < NR; p++) s_ra[p] = AW'((p % 4) + 1 + (p / 4) * 0);
    s_ra[3] = 5'd4; s_ra[7] = 5'd1;
    step("R1");

    // R5: slots 0,1,3 all target register 5, slot 2 targets 9
    clear_stim();
    s_en = 4'b1111;
    s_wa[0] = 5'd5; s_wa[1] = 5'd5; s_wa[2] = 5'd9; s_wa[3] = 5'd5;
    s_wd[0] = 64'h0; s_wd[1] = 64'h1111; s_wd[2] = 64'h9999; s_wd[3] = 64'h3333;
    step("R1");
    clear_stim();
    for (int p = 0; p < NR; p++) s_ra[p] = (p % 2 == 0) ? 5'd5 : 5'd9;
    step("R5");

    // R5: older slot wins when younger is disabled
    clear_stim();
    s_en = 4'b0001; s_wa[0] = 5'd6; s_wa[3] = 5'd6;
    s_wd[0] = 64'h6666; s_wd[3] = 64'hDEAD;
    step("R5");
    clear_stim();
    for (int p = 0; p < NR; p++) s_ra[p] = 5'd6;
    step("R5");

    // R4: read while writing returns old value, then the new one
    clear_stim();
    s_en = 4'b0100; s_wa[2] = 5'd7; s_wd[2] = 64'hAAAA_0001;
    step("R5");
    clear_stim();
    s_en = 4'b0010; s_wa[1] = 5'd7; s_wd[1] = 64'hBBBB_0002;
    for (int p = 0; p < NR; p++) s_ra[p] = 5'd7;
    step("R4");
    clear_stim();
    for (int p = 0; p < NR; p++) s_ra[p] = 5'd7;
    step("R4");

    // R6: writes to register 0 are dropped
    clear_stim();
    s_en = 4'b1111;
    for (int i = 0; i < NW; i++) begin s_wa[i] = '0; s_wd[i] = 64'hFFFF_FFFF_FFFF_FFFF; end
    step("R4");
    clear_stim();
    step("R6");

    // R8: disabled slots leave registers untouched
    clear_stim();
    s_en = 4'b0000;
    for (int i = 0; i < NW; i++) begin s_wa[i] = AW'(i + 1); s_wd[i] = 64'hBAD0_BAD0; end
    step("R6");
    clear_stim();
    for (int p = 0; p < NR; p++) s_ra[p] = AW'((p % 4) + 1);
    step("R8");

    // R3 / R2: random traffic, clusters often read the same registers
    for (int n = 0; n < 400; n++) begin
      clear_stim();
      s_en = 4'($urandom);
      for (int i = 0; i < NW; i++) begin
        s_wa[i] = AW'($urandom % ((n % 3 == 0) ? 4 : NREG));
        s_wd[i] = {$urandom, $urandom};
      end
      for (int p = 0; p < 4; p++) begin
        s_ra[p] = AW'($urandom % NREG);
        s_ra[p+4] = (n % 2 == 0) ? s_ra[p] : AW'($urandom % NREG);
      end
      step((n % 2 == 0) ? "R2" : "R3");
    end

    // R2: sweep every register through both clusters at once
    for (int k = 0; k < NREG / 4; k++) begin
      clear_stim();
      for (int p = 0; p < NR; p++) s_ra[p] = AW'(k * 4 + (p % 4));
      step("R3");
    end
    clear_stim();
    step("R2");

    // R7: reset in the middle of traffic clears everything
    clear_stim();
    s_en = 4'b1111;
    for (int i = 0; i < NW; i++) begin s_wa[i] = AW'(10 + i); s_wd[i] = 64'h7777; end
    step("R2");
    do_reset();
    for (int k = 0; k < NREG / 4; k++) begin
      clear_stim();
      for (int p = 0; p < NR; p++) s_ra[p] = AW'(k * 4 + (p % 4));
      step("R7");
    end
    clear_stim();
    step("R7");
    @(negedge clk);

    done = 1;
    summary();
    $finish;
  end

endmodule